// File: doc/BRIEF.md
# Flag-Setting 32-bit ALU

This block is the integer execution datapath of a small processor core. It is purely combinational. It takes operand A from the register file and operand B after the barrel shifter. It also takes the carry bit that the shifter produced and the current condition flags. From these it forms a 32-bit result, a strobe that says whether the result is to be written back, the next value of the four condition flags (negative, zero, carry, overflow) and a strobe that says whether the flag register is to be loaded.

A 4-bit operation code selects one of twelve operations:

- four bitwise operations: AND, OR, XOR and bit clear;
- three additions: add, subtract and add-with-carry;
- two moves: copy and complement;
- three flag-only comparisons: AND-test, XOR-test and subtract-compare.

The comparisons always load the flags and never write a result. Every other operation writes its result, and it loads the flags only when the set-flags input is high. Because add-with-carry consumes the incoming carry flag, a flag-setting add on the low word followed by an add-with-carry on the high word builds a 64-bit sum.

Internally a decoder sorts each operation code into one of four classes: bitwise/move, arithmetic, compare, and unused. A bitwise unit and an adder compute their results in parallel. A flag unit then forms the next flags from the class and the data.

Top module: `flag_alu`

## Requirements
- R1: The bitwise operation codes produce the following results. Code 4'h0 gives A AND B. Code 4'h1 gives A OR B. Code 4'h2 gives A XOR B. Code 4'h3 gives A AND (NOT B); for example 0x02FA62CA with 0x0000FFFF gives 0x02FA0000.
- R2: The arithmetic operation codes produce the following results, all modulo 2^32. Code 4'h4 gives A+B. Code 4'h5 gives A-B. Code 4'h6 gives A+B+C, where C is bit 1 of `flags_i`.
- R3: Code 4'h7 returns B unchanged, and code 4'h8 returns the bitwise complement of B.
- R4: The compare codes behave as follows. Code 4'h9 evaluates A AND B, code 4'hA evaluates A XOR B, and code 4'hB evaluates A-B. For all three, `res_we_o` is 0 and `flags_we_o` is 1 whatever `setf_i` is. `res_o` still shows the evaluated value.
- R5: Codes 4'h0 through 4'h8 set `res_we_o` to 1. They set `flags_we_o` equal to `setf_i`.
- R6: When `flags_we_o` is 0, `flags_o` equals `flags_i`.
- R7: The flag vector is laid out as bit 3 N, bit 2 Z, bit 1 C, bit 0 V. On a flag update, N equals bit 31 of `res_o`, and Z is 1 exactly when `res_o` is zero. XOR-test of equal operands therefore sets Z.
- R8: For add and add-with-carry, C is the carry out of bit 31. For subtract and compare, C is 1 when no borrow occurs. For all arithmetic and compare-subtract operations, V is 1 on two's-complement overflow.
- R9: For bitwise, move, AND-test and XOR-test operations, an update loads C from `shc_i` and keeps V from `flags_i`.
- R10: Codes 4'hC to 4'hF drive `res_o` to zero and both strobes to 0.
- R11: A flag-setting add of the low words followed by an add-with-carry of the high words, with the flags fed back, yields the 64-bit sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B, already shifted |
| shc_i | input | 1 | Carry out of the operand shifter |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| op_i | input | 4 | Operation code |
| setf_i | input | 1 | Set-flags request for ordinary operations |
| res_o | output | 32 | Result |
| res_we_o | output | 1 | Result write strobe |
| flags_o | output | 4 | Next flags {N,Z,C,V} |
| flags_we_o | output | 1 | Flag register load strobe |

## Verification
The embedded checks assume the inputs are settled, two-state values each time the combinational logic is evaluated. They treat every 4-bit operation code as legal, including the four unused ones. The stimulus follows these assumptions:

- It changes all inputs together on the falling clock edge and samples only after the logic has settled.
- It drives every input to a known value before the first evaluation.
- Where one operation follows another, as in the 64-bit chain, the next-flag output is fed back as the flag input.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_AND  = 4'h0,
        OP_OR   = 4'h1,
        OP_XOR  = 4'h2,
        OP_BCLR = 4'h3,
        OP_ADD  = 4'h4,
        OP_SUB  = 4'h5,
        OP_ADDC = 4'h6,
        OP_MOVE = 4'h7,
        OP_MOVN = 4'h8,
        OP_TAND = 4'h9,
        OP_TXOR = 4'hA,
        OP_CMP  = 4'hB
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_BITWISE,
        CLS_ARITH,
        CLS_COMPARE,
        CLS_UNUSED
    } op_class_e;

    typedef enum logic [2:0] {
        LG_AND,
        LG_OR,
        LG_XOR,
        LG_BCLR,
        LG_PASS,
        LG_INV
    } logic_sel_e;

    typedef enum logic [1:0] {
        CIN_ZERO,
        CIN_ONE,
        CIN_FLAG
    } cin_sel_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/alu_decoder.sv
module alu_decoder
    import alu_pkg::*;
(
    input  logic [3:0] op_i,
    output op_class_e  cls_o,
    output logic_sel_e lsel_o,
    output logic       use_adder_o,
    output logic       binv_o,
    output cin_sel_e   cin_o,
    output logic       wr_res_o,
    output logic       force_flags_o
);

    always_comb begin
        cls_o         = CLS_UNUSED;
        lsel_o        = LG_AND;
        use_adder_o   = 1'b0;
        binv_o        = 1'b0;
        cin_o         = CIN_ZERO;
        wr_res_o      = 1'b0;
        force_flags_o = 1'b0;
        unique case (op_i)
            OP_AND:  begin cls_o = CLS_BITWISE; lsel_o = LG_AND;  wr_res_o = 1'b1; end
            OP_OR:   begin cls_o = CLS_BITWISE; lsel_o = LG_OR;   wr_res_o = 1'b1; end
            OP_XOR:  begin cls_o = CLS_BITWISE; lsel_o = LG_XOR;  wr_res_o = 1'b1; end
            OP_BCLR: begin cls_o = CLS_BITWISE; lsel_o = LG_BCLR; wr_res_o = 1'b1; end
            OP_MOVE: begin cls_o = CLS_BITWISE; lsel_o = LG_PASS; wr_res_o = 1'b1; end
            OP_MOVN: begin cls_o = CLS_BITWISE; lsel_o = LG_INV;  wr_res_o = 1'b1; end
            OP_ADD: begin
                cls_o = CLS_ARITH; use_adder_o = 1'b1; wr_res_o = 1'b1;
            end
            OP_SUB: begin
                cls_o = CLS_ARITH; use_adder_o = 1'b1; wr_res_o = 1'b1;
                binv_o = 1'b1; cin_o = CIN_ONE;
            end
            OP_ADDC: begin
                cls_o = CLS_ARITH; use_adder_o = 1'b1; wr_res_o = 1'b1;
                cin_o = CIN_FLAG;
            end
            OP_TAND: begin
                cls_o = CLS_COMPARE; lsel_o = LG_AND; force_flags_o = 1'b1;
            end
            OP_TXOR: begin
                cls_o = CLS_COMPARE; lsel_o = LG_XOR; force_flags_o = 1'b1;
            end
            OP_CMP: begin
                cls_o = CLS_COMPARE; use_adder_o = 1'b1; force_flags_o = 1'b1;
                binv_o = 1'b1; cin_o = CIN_ONE;
            end
            default: begin
                cls_o = CLS_UNUSED;
            end
        endcase
    end

    always_comb begin
        // R4
        cmp_no_write_chk: assert (!(cls_o == CLS_COMPARE) || (!wr_res_o && force_flags_o));
        // R10
        unused_quiet_chk: assert (!(cls_o == CLS_UNUSED) || (!wr_res_o && !force_flags_o && !use_adder_o));
    end

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic_sel_e       sel_i,
    output logic [WIDTH-1:0] y_o
);

    always_comb begin
        unique case (sel_i)
            LG_AND:  y_o = a_i & b_i;
            LG_OR:   y_o = a_i | b_i;
            LG_XOR:  y_o = a_i ^ b_i;
            LG_BCLR: y_o = a_i & ~b_i;
            LG_PASS: y_o = b_i;
            LG_INV:  y_o = ~b_i;
            default: y_o = '0;
        endcase
    end

    always_comb begin
        // R1
        bclr_clears_chk: assert (!(sel_i == LG_BCLR) || ((y_o & b_i) == '0));
        // R3
        inv_disjoint_chk: assert (!(sel_i == LG_INV) || ((y_o ^ b_i) == {WIDTH{1'b1}}));
    end

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             binv_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             ovf_o
);

    localparam int EXT = WIDTH + 1;

    logic [WIDTH-1:0] b_eff;
    logic [EXT-1:0]   wide;

    always_comb begin
        b_eff  = binv_i ? ~b_i : b_i;
        wide   = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin_i};
        sum_o  = wide[WIDTH-1:0];
        cout_o = wide[WIDTH];
        ovf_o  = (a_i[WIDTH-1] == b_eff[WIDTH-1]) && (sum_o[WIDTH-1] != a_i[WIDTH-1]);
    end

    always_comb begin
        // R8
        sub_borrow_chk: assert (!(binv_i && cin_i) || (cout_o == (a_i >= b_i)));
    end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] res_i,
    input  logic             from_adder_i,
    input  logic             cout_i,
    input  logic             ovf_i,
    input  logic             shc_i,
    input  flags_t           flags_i,
    input  logic             upd_i,
    output flags_t           flags_o
);

    flags_t fresh;

    always_comb begin
        fresh.n = res_i[WIDTH-1];
        fresh.z = (res_i == '0);
        if (from_adder_i) begin
            fresh.c = cout_i;
            fresh.v = ovf_i;
        end else begin
            fresh.c = shc_i;
            fresh.v = flags_i.v;
        end
        flags_o = upd_i ? fresh : flags_i;
    end

    always_comb begin
        // R6
        hold_flags_chk: assert (upd_i || (flags_o == flags_i));
        // R9
        shift_carry_chk: assert (!(upd_i && !from_adder_i) || (flags_o.c == shc_i && flags_o.v == flags_i.v));
    end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [31:0] opa_i,
    input  logic [31:0] opb_i,
    input  logic        shc_i,
    input  logic [3:0]  flags_i,
    input  logic [3:0]  op_i,
    input  logic        setf_i,
    output logic [31:0] res_o,
    output logic        res_we_o,
    output logic [3:0]  flags_o,
    output logic        flags_we_o
);

    op_class_e  cls;
    logic_sel_e lsel;
    logic       use_adder;
    logic       binv;
    cin_sel_e   cin_sel;
    logic       wr_res;
    logic       force_flags;

    logic [WIDTH-1:0] a_w;
    logic [WIDTH-1:0] b_w;
    logic [WIDTH-1:0] logic_y;
    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] result;
    logic             cout;
    logic             ovf;
    logic             cin;
    logic             upd;
    flags_t           cur_flags;
    flags_t           nxt_flags;

    assign a_w       = opa_i[WIDTH-1:0];
    assign b_w       = opb_i[WIDTH-1:0];
    assign cur_flags = flags_t'(flags_i);

    alu_decoder dec_i (
        .op_i         (op_i),
        .cls_o        (cls),
        .lsel_o       (lsel),
        .use_adder_o  (use_adder),
        .binv_o       (binv),
        .cin_o        (cin_sel),
        .wr_res_o     (wr_res),
        .force_flags_o(force_flags)
    );

    alu_logic_unit #(.WIDTH(WIDTH)) lu_i (
        .a_i  (a_w),
        .b_i  (b_w),
        .sel_i(lsel),
        .y_o  (logic_y)
    );

    always_comb begin
        unique case (cin_sel)
            CIN_ONE:  cin = 1'b1;
            CIN_FLAG: cin = cur_flags.c;
            default:  cin = 1'b0;
        endcase
    end

    alu_adder #(.WIDTH(WIDTH)) add_i (
        .a_i   (a_w),
        .b_i   (b_w),
        .binv_i(binv),
        .cin_i (cin),
        .sum_o (sum),
        .cout_o(cout),
        .ovf_o (ovf)
    );

    always_comb begin
        unique case (cls)
            CLS_UNUSED: result = '0;
            default:    result = use_adder ? sum : logic_y;
        endcase
        upd = force_flags || (setf_i && wr_res);
    end

    alu_flag_unit #(.WIDTH(WIDTH)) fl_i (
        .res_i       (result),
        .from_adder_i(use_adder),
        .cout_i      (cout),
        .ovf_i       (ovf),
        .shc_i       (shc_i),
        .flags_i     (cur_flags),
        .upd_i       (upd),
        .flags_o     (nxt_flags)
    );

    assign res_o      = result;
    assign res_we_o   = wr_res;
    assign flags_o    = nxt_flags;
    assign flags_we_o = upd;

    always_comb begin
        // R5
        setf_gate_chk: assert (!res_we_o || (flags_we_o == setf_i));
        // R7
        zero_flag_chk: assert (!flags_we_o || (flags_o[2] == (res_o == 32'd0)));
        // R7
        neg_flag_chk: assert (!flags_we_o || (flags_o[3] == res_o[31]));
        // R10
        unused_result_chk: assert (!(op_i >= 4'hC) || (res_o == 32'd0 && !res_we_o && !flags_we_o));
    end

endmodule

// File: tb/flag_alu_tb.sv
module flag_alu_tb_top;

    typedef struct packed {
        logic [3:0]  op;
        logic        setf;
        logic [31:0] a;
        logic [31:0] b;
        logic        shc;
        logic [3:0]  fin;
        logic [31:0] res;
        logic        we;
        logic [3:0]  fo;
        logic        fwe;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{4'h0, 1'b1, 32'hF0F00000, 32'hFF0000FF, 1'b1, 4'b0001, 32'hF0000000, 1'b1, 4'b1011, 1'b1, 8'd1},  // R1 R9
        '{4'h1, 1'b0, 32'h00001234, 32'h80000000, 1'b0, 4'b0100, 32'h80001234, 1'b1, 4'b0100, 1'b0, 8'd1},  // R1 R6
        '{4'h2, 1'b1, 32'h5A5A5A5A, 32'h5A5A5A5A, 1'b0, 4'b1000, 32'h00000000, 1'b1, 4'b0100, 1'b1, 8'd7},  // R7
        '{4'h3, 1'b0, 32'h02FA62CA, 32'h0000FFFF, 1'b0, 4'b0000, 32'h02FA0000, 1'b1, 4'b0000, 1'b0, 8'd1},  // R1
        '{4'h4, 1'b1, 32'hFFFFFFFF, 32'h00000001, 1'b0, 4'b0000, 32'h00000000, 1'b1, 4'b0110, 1'b1, 8'd8},  // R8
        '{4'h4, 1'b1, 32'h7FFFFFFF, 32'h00000001, 1'b0, 4'b0000, 32'h80000000, 1'b1, 4'b1001, 1'b1, 8'd8},  // R8
        '{4'h5, 1'b1, 32'h00000005, 32'h00000007, 1'b0, 4'b0000, 32'hFFFFFFFE, 1'b1, 4'b1000, 1'b1, 8'd8},  // R8
        '{4'h5, 1'b1, 32'h80000000, 32'h00000001, 1'b0, 4'b0000, 32'h7FFFFFFF, 1'b1, 4'b0011, 1'b1, 8'd8},  // R8
        '{4'h6, 1'b1, 32'h00000001, 32'h00000002, 1'b0, 4'b0010, 32'h00000004, 1'b1, 4'b0000, 1'b1, 8'd2},  // R2
        '{4'h6, 1'b0, 32'h00000001, 32'h00000002, 1'b0, 4'b0000, 32'h00000003, 1'b1, 4'b0000, 1'b0, 8'd2},  // R2 R5
        '{4'h7, 1'b1, 32'h12345678, 32'h00000000, 1'b1, 4'b0001, 32'h00000000, 1'b1, 4'b0111, 1'b1, 8'd3},  // R3 R9
        '{4'h8, 1'b1, 32'h00000000, 32'h00000004, 1'b0, 4'b0000, 32'hFFFFFFFB, 1'b1, 4'b1000, 1'b1, 8'd3},  // R3
        '{4'h9, 1'b0, 32'h00000003, 32'h00000001, 1'b0, 4'b0000, 32'h00000001, 1'b0, 4'b0000, 1'b1, 8'd4},  // R4
        '{4'h9, 1'b0, 32'h00000002, 32'h00000001, 1'b1, 4'b0000, 32'h00000000, 1'b0, 4'b0110, 1'b1, 8'd4},  // R4 R9
        '{4'hA, 1'b0, 32'h00000005, 32'h00000005, 1'b0, 4'b0000, 32'h00000000, 1'b0, 4'b0100, 1'b1, 8'd7},  // R7
        '{4'hA, 1'b0, 32'h00000005, 32'h00000006, 1'b0, 4'b0000, 32'h00000003, 1'b0, 4'b0000, 1'b1, 8'd4},  // R4
        '{4'hB, 1'b0, 32'h00000007, 32'h00000007, 1'b0, 4'b0000, 32'h00000000, 1'b0, 4'b0110, 1'b1, 8'd8},  // R8
        '{4'hB, 1'b0, 32'h00000003, 32'h00000009, 1'b0, 4'b0000, 32'hFFFFFFFA, 1'b0, 4'b1000, 1'b1, 8'd8},  // R8
        '{4'hD, 1'b1, 32'h00000001, 32'h00000001, 1'b1, 4'b1010, 32'h00000000, 1'b0, 4'b1010, 1'b0, 8'd10}  // R10
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic        shc_i = 1'b0;
    logic [3:0]  flags_i = '0;
    logic [3:0]  op_i = '0;
    logic        setf_i = 1'b0;
    logic [31:0] res_o;
    logic        res_we_o;
    logic [3:0]  flags_o;
    logic        flags_we_o;

    int checks = 0;
    int fails  = 0;

    flag_alu dut_i (
        .opa_i     (opa_i),
        .opb_i     (opb_i),
        .shc_i     (shc_i),
        .flags_i   (flags_i),
        .op_i      (op_i),
        .setf_i    (setf_i),
        .res_o     (res_o),
        .res_we_o  (res_we_o),
        .flags_o   (flags_o),
        .flags_we_o(flags_we_o)
    );

    task automatic drive(input logic [3:0] op, input logic sf, input logic [31:0] a,
                         input logic [31:0] b, input logic sc, input logic [3:0] fl);
        @(negedge clk);
        op_i = op; setf_i = sf; opa_i = a; opb_i = b; shc_i = sc; flags_i = fl;
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string tag, input logic [31:0] res, input logic we,
                         input logic [3:0] fo, input logic fwe);
        checks++;
        if (res_o !== res || res_we_o !== we || flags_o !== fo || flags_we_o !== fwe) begin
            fails++;
            $display("FAIL %s actual res=%h we=%b flags=%b fwe=%b expected res=%h we=%b flags=%b fwe=%b",
                     tag, res_o, res_we_o, flags_o, flags_we_o, res, we, fo, fwe);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R11 actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R5 R6: idle state with all inputs zero (AND, no set-flags)
        drive(4'h0, 1'b0, 32'h0, 32'h0, 1'b0, 4'b0000);
        check("R5 idle", 32'h0, 1'b1, 4'b0000, 1'b0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].op, VECS[i].setf, VECS[i].a, VECS[i].b, VECS[i].shc, VECS[i].fin);
            check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].res, VECS[i].we,
                  VECS[i].fo, VECS[i].fwe);
        end

        // R11: 64-bit chain 0x00000001_FFFFFFFF + 0x00000002_00000001
        begin
            logic [3:0] f;
            drive(4'h4, 1'b1, 32'hFFFFFFFF, 32'h00000001, 1'b0, 4'b0000);
            check("R11 low", 32'h00000000, 1'b1, 4'b0110, 1'b1);
            f = flags_o;
            drive(4'h6, 1'b1, 32'h00000001, 32'h00000002, 1'b0, f);
            check("R11 high", 32'h00000004, 1'b1, 4'b0000, 1'b1);
        end

        // R4: compare ignores set-flags being high
        drive(4'hB, 1'b1, 32'h00000010, 32'h00000001, 1'b0, 4'b0000);
        check("R4 cmp setf", 32'h0000000F, 1'b0, 4'b0010, 1'b1);

        // R10: every unused code is silent
        for (int k = 12; k < 16; k++) begin
            drive(4'(k), 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 4'b0101);
            check($sformatf("R10 code%0d", k), 32'h0, 1'b0, 4'b0101, 1'b0);
        end

        // R6: flags held through a non-flag-setting subtract
        drive(4'h5, 1'b0, 32'h00000000, 32'h00000001, 1'b1, 4'b1111);
        check("R6 hold", 32'hFFFFFFFF, 1'b1, 4'b1111, 1'b0);

        // R2 R8: add-with-carry overflow with carry in
        drive(4'h6, 1'b1, 32'h7FFFFFFF, 32'h00000000, 1'b0, 4'b0010);
        check("R8 adc ovf", 32'h80000000, 1'b1, 4'b1001, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule